// File: doc/BRIEF.md
# Chained converter readback controller

This block is the host side of a 3-wire link to a daisy chain of identical 14-bit converters. On a start request it raises the convert line while the serial clock sits high. That puts every converter in the chain into its chained mode with the completion indicator. It then watches the data line returned by the converter nearest the host. When that line goes high, every device has finished. The block then generates the readback clocks itself and captures the returned data on each falling clock edge it produces.

The first captured bit is the completion indicator and is thrown away. The following bits are packed into one result word per converter, most significant bit first, nearest converter first. Each word is presented with a one-cycle valid strobe and its position in the chain. After the last clock the serial clock goes back to high and the convert line is released. If the data line never rises, a wait limit ends the cycle, releases the convert line and raises an error flag.

Top module: `chain_rdbk_ctrl`

## Requirements
- R1: After reset `cnv_o`=0, `sck_o`=1, `busy_o`=0, `word_valid_o`=0 and `err_o`=0.
- R2: A `start_i` sampled high while idle makes `cnv_o` and `busy_o` high from the next clock edge, with `sck_o` high at the moment `cnv_o` rises. `err_o` is cleared by that same edge.
- R3: While `cnv_o` is high and `sdo_i` has not yet been seen high, `sck_o` makes no transitions. `sck_o` is high whenever `cnv_o` is low.
- R4: Readback starts only after `sdo_i` is sampled high. A completed cycle produces exactly 14×NDEV+1 falling edges on `sck_o`.
- R5: During readback every `sck_o` level lasts exactly SCK_HALF system clocks.
- R6: The bit sampled at the first falling edge is discarded. The next 14×NDEV bits form NDEV words, each received MSB first. The word from the converter nearest the host comes first with `word_idx_o`=0, and the index rises by one per word.
- R7: Each word is presented with `word_valid_o` high for exactly one cycle.
- R8: If `sdo_i` stays low for WAIT_LIMIT cycles after `cnv_o` rises, `cnv_o` falls after exactly WAIT_LIMIT high cycles. `err_o` then goes high, and no clocks and no words are produced.
- R9: A `start_i` received while `busy_o` is high has no effect: `cnv_o` rises only once per cycle and the word count is unchanged.
- R10: `cnv_o` and `busy_o` fall on the same clock edge that returns `sck_o` high after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion and readback cycle |
| sdo_i | input | 1 | Serial data from the converter nearest the host |
| cnv_o | output | 1 | Convert line shared by the chain |
| sck_o | output | 1 | Serial clock, idle high |
| busy_o | output | 1 | High while a cycle is in progress |
| word_valid_o | output | 1 | One-cycle strobe for a received word |
| word_data_o | output | WORD_W | Received result word |
| word_idx_o | output | IDX_W | Chain position of the word, 0 = nearest |
| err_o | output | 1 | Set when the completion wait timed out |

## Verification
The hardest situations to reach are the ones where the converters never signal completion, or where a new request arrives in the middle of a cycle. Neither can happen with a well-behaved chain. The bench therefore uses a behavioural chain model that can be told to hold its data line low forever, which forces the wait limit, the error flag and a clock-free release. The bench also pulses start both during the completion wait and during readback, then counts rising edges of the convert line and the words received. The model's completion delay is varied down to a single cycle, so that readback starts almost at once after the convert line rises.

// File: rtl/chain_pkg.sv
package chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } ctl_state_e;

  // falling clock edges for one full readback: indicator bit plus all words
  function automatic int unsigned chain_clocks(int unsigned ndev, int unsigned wbits);
    return ndev * wbits + 1;
  endfunction

  // bits needed to hold values 0 .. v-1 (at least one)
  function automatic int unsigned cnt_width(int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/chain_sck_gen.sv
module chain_sck_gen
  import chain_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic fall_evt_o,
  output logic rise_evt_o
);

  localparam int unsigned CW = cnt_width(SCK_HALF);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(SCK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o      = sck_q;
  assign fall_evt_o = tick & sck_q;
  assign rise_evt_o = tick & ~sck_q;

endmodule

// File: rtl/chain_word_asm.sv
module chain_word_asm
  import chain_pkg::*;
#(
  parameter int unsigned NDEV   = 3,
  parameter int unsigned WORD_W = 14,
  localparam int unsigned IW    = cnt_width(NDEV),
  localparam int unsigned BW    = cnt_width(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              bit_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic [IW-1:0]     idx_o
);

  logic              first_q;
  logic [BW-1:0]     bitpos_q;
  logic [WORD_W-1:0] sr_q;
  logic [IW-1:0]     widx_q;
  logic [WORD_W-1:0] next_word;
  logic              word_end;

  assign next_word = {sr_q[WORD_W-2:0], bit_i};
  assign word_end  = (bitpos_q == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= 1'b1;
      bitpos_q <= '0;
      sr_q     <= '0;
      widx_q   <= '0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      idx_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        first_q  <= 1'b1;
        bitpos_q <= '0;
        widx_q   <= '0;
      end else if (cap_i) begin
        if (first_q) begin
          first_q <= 1'b0;          // completion indicator bit
        end else begin
          sr_q <= next_word;
          if (word_end) begin
            bitpos_q <= '0;
            valid_o  <= 1'b1;
            data_o   <= next_word;
            idx_o    <= widx_q;
            widx_q   <= widx_q + 1'b1;
          end else begin
            bitpos_q <= bitpos_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/chain_wait_timer.sv
module chain_wait_timer
  import chain_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic expire_o
);

  localparam int unsigned TW = cnt_width(WAIT_LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!arm_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = arm_i && (cnt_q == TW'(WAIT_LIMIT - 1));

endmodule

// File: rtl/chain_rdbk_ctrl.sv
module chain_rdbk_ctrl
  import chain_pkg::*;
#(
  parameter int unsigned NDEV       = 3,
  parameter int unsigned WORD_W     = 14,
  parameter int unsigned SCK_HALF   = 2,
  parameter int unsigned WAIT_LIMIT = 200,
  localparam int unsigned IDX_W     = cnt_width(NDEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sck_o,
  output logic              busy_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              err_o
);

  localparam int unsigned TOTAL = chain_clocks(NDEV, WORD_W);
  localparam int unsigned FW    = cnt_width(TOTAL + 1);

  ctl_state_e    st_q;
  logic          cnv_q;
  logic          err_q;
  logic [FW-1:0] fcnt_q;

  // named internal events
  logic start_accept;
  logic fall_evt;
  logic rise_evt;
  logic done_evt;
  logic tmo_expire;
  logic in_wait;
  logic in_shift;

  assign in_wait      = (st_q == ST_WAIT);
  assign in_shift     = (st_q == ST_SHIFT);
  assign start_accept = (st_q == ST_IDLE) && start_i;
  assign done_evt     = in_shift && rise_evt && (fcnt_q == FW'(TOTAL));

  chain_sck_gen #(.SCK_HALF(SCK_HALF)) sck_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (in_shift),
    .sck_o      (sck_o),
    .fall_evt_o (fall_evt),
    .rise_evt_o (rise_evt)
  );

  chain_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (in_wait && !sdo_i),
    .expire_o (tmo_expire)
  );

  chain_word_asm #(.NDEV(NDEV), .WORD_W(WORD_W)) asm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (in_wait),
    .cap_i   (in_shift && fall_evt),
    .bit_i   (sdo_i),
    .valid_o (word_valid_o),
    .data_o  (word_data_o),
    .idx_o   (word_idx_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnv_q  <= 1'b0;
      err_q  <= 1'b0;
      fcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_WAIT;
            cnv_q <= 1'b1;
            err_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          fcnt_q <= '0;
          if (sdo_i) begin
            st_q <= ST_SHIFT;
          end else if (tmo_expire) begin
            st_q  <= ST_IDLE;
            cnv_q <= 1'b0;
            err_q <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall_evt) fcnt_q <= fcnt_q + 1'b1;
          if (done_evt) begin
            st_q  <= ST_IDLE;
            cnv_q <= 1'b0;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnv_q <= 1'b0;
        end
      endcase
    end
  end

  assign cnv_o  = cnv_q;
  assign busy_o = (st_q != ST_IDLE);
  assign err_o  = err_q;

endmodule

// File: rtl/chain_rdbk_chk.sv
module chain_rdbk_chk
  import chain_pkg::*;
#(
  parameter int unsigned NDEV   = 3,
  parameter int unsigned WORD_W = 14
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sck_o,
  input logic busy_o,
  input logic word_valid_o,
  input logic err_o,
  input logic fall_evt,
  input logic start_accept
);

  localparam int unsigned TOTAL = chain_clocks(NDEV, WORD_W);
  localparam int unsigned FW    = cnt_width(TOTAL + 2);

  logic [FW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (!cnv_o)   seen_q <= '0;
    else if (fall_evt) seen_q <= seen_q + 1'b1;
  end

  assert_start_raises_cnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (cnv_o && busy_o));

  assert_sck_high_at_cnv_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sck_o);

  assert_sck_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_o |-> sck_o);

  assert_fall_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> (seen_q < FW'(TOTAL)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  assert_word_inside_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> cnv_o);

  assert_err_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!cnv_o && $past(cnv_o)));

  assert_busy_tracks_cnv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == cnv_o);

endmodule

bind chain_rdbk_ctrl chain_rdbk_chk #(.NDEV(NDEV), .WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnv_o        (cnv_o),
  .sck_o        (sck_o),
  .busy_o       (busy_o),
  .word_valid_o (word_valid_o),
  .err_o        (err_o),
  .fall_evt     (fall_evt),
  .start_accept (start_accept)
);

// File: tb/chain_rdbk_ctrl_tb_top.sv
`timescale 1ns/1ps
module chain_rdbk_ctrl_tb_top;

  localparam int NDEV  = 3;
  localparam int WW    = 14;
  localparam int HALF  = 2;
  localparam int WLIM  = 200;
  localparam int TOTAL = NDEV * WW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b0;
  logic cnv, sck, busy, wvalid, err;
  logic [WW-1:0] wdata;
  logic [1:0]    widx;

  always #2 clk = ~clk;

  chain_rdbk_ctrl #(.NDEV(NDEV), .WORD_W(WW), .SCK_HALF(HALF), .WAIT_LIMIT(WLIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sdo_i(sdo), .cnv_o(cnv), .sck_o(sck),
    .busy_o(busy), .word_valid_o(wvalid), .word_data_o(wdata), .word_idx_o(widx), .err_o(err)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // ---------------- chain model ----------------
  logic [WW-1:0] stream_w [NDEV];
  int  conv_len = 10;
  bit  never_done = 0;
  int  conv_cnt = 0, pos = 0, cyc = 0;
  bit  cnv_prev = 0, sck_prev = 1, in_rd = 0, have_last = 0;
  int  last_tr = 0;
  int  falls = 0, early_tr = 0, gap_bad = 0, cnv_rises = 0, cnv_high = 0;
  int  rise_sck_bad = 0, end_bad = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (cnv) cnv_high++;
    if (cnv && !cnv_prev) begin
      cnv_rises++;
      if (!sck) rise_sck_bad++;
      conv_cnt = conv_len; sdo = 0; in_rd = 0; have_last = 0; pos = 0;
    end else if (!cnv) begin
      if (cnv_prev && !(sck && !sck_prev)) end_bad++;
      sdo = 0; in_rd = 0;
    end else begin
      if (sck != sck_prev) begin
        if (!in_rd) early_tr++;
        if (have_last && (cyc - last_tr) != HALF) gap_bad++;
        have_last = 1; last_tr = cyc;
      end
      if (conv_cnt > 0) begin
        conv_cnt--;
        if (conv_cnt == 0 && !never_done) begin sdo = 1; in_rd = 1; end
      end else if (sck_prev && !sck) begin
        falls++;
        if (pos < NDEV * WW) sdo = stream_w[pos / WW][WW - 1 - (pos % WW)];
        else sdo = 0;
        pos++;
      end
    end
    cnv_prev = cnv; sck_prev = sck;
  end

  // ---------------- scoreboard ----------------
  int exp_data[$];
  int exp_idx[$];
  int words_seen = 0;
  bit v_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (v_prev && wvalid) chk(0, "R7 valid longer than one cycle", 1, 0);
      if (wvalid) begin
        words_seen++;
        if (exp_data.size() == 0) chk(0, "R6 unexpected word", int'(wdata), -1);
        else begin
          int ed, ei;
          ed = exp_data.pop_front(); ei = exp_idx.pop_front();
          chk(int'(wdata) == ed, "R6 word data", int'(wdata), ed);
          chk(int'(widx) == ei, "R6 word index", int'(widx), ei);
        end
      end
      v_prev = wvalid;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_stats();
    falls = 0; early_tr = 0; gap_bad = 0; cnv_rises = 0; cnv_high = 0;
    rise_sck_bad = 0; end_bad = 0; words_seen = 0;
  endtask

  // driver: one full cycle with given words; optional extra start pulses
  task automatic run_cycle(input int w0, input int w1, input int w2,
                           input int clen, input bit poke);
    clear_stats();
    stream_w[0] = WW'(w0); stream_w[1] = WW'(w1); stream_w[2] = WW'(w2);
    conv_len = clen; never_done = 0;
    exp_data.push_back(w0); exp_idx.push_back(0);
    exp_data.push_back(w1); exp_idx.push_back(1);
    exp_data.push_back(w2); exp_idx.push_back(2);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(cnv && busy, "R2 cnv/busy one cycle after start", int'(cnv), 1);
    chk(!err, "R2 err cleared by start", int'(err), 0);
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1; @(negedge clk); start = 0;       // during wait
      repeat (clen + 20) @(negedge clk);
      start = 1; @(negedge clk); start = 0;       // during readback
    end
    wait_idle();
    chk(rise_sck_bad == 0, "R2 sck high at cnv rise", rise_sck_bad, 0);
    chk(early_tr == 0, "R3 sck moved before completion", early_tr, 0);
    chk(falls == TOTAL, "R4 falling edge count", falls, TOTAL);
    chk(gap_bad == 0, "R5 half-period violations", gap_bad, 0);
    chk(words_seen == NDEV && exp_data.size() == 0, "R6 words received", words_seen, NDEV);
    chk(cnv_rises == 1, "R9 cnv rises per cycle", cnv_rises, 1);
    chk(end_bad == 0, "R10 cnv falls with final sck rise", end_bad, 0);
    chk(!cnv && sck && !busy, "R10 idle after cycle", int'({cnv, sck, busy}), 2);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk(!cnv, "R1 cnv after reset", int'(cnv), 0);
    chk(sck, "R1 sck after reset", int'(sck), 1);
    chk(!busy && !wvalid && !err, "R1 busy/valid/err after reset",
        int'({busy, wvalid, err}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!cnv && sck, "R1 idle after reset release", int'({cnv, sck}), 1);

    run_cycle(14'h3FFF, 14'h0000, 14'h3FFF, 10, 0);
    run_cycle(14'h2AAA, 14'h1555, 14'h2001, 25, 0);
    run_cycle(14'h0001, 14'h2000, 14'h1234, 1, 0);
    run_cycle(14'h0F0F, 14'h30C3, 14'h0ABC, 15, 1);

    // R8: chain never signals completion
    clear_stats();
    never_done = 1; conv_len = 5;
    pulse_start();
    wait_idle();
    chk(cnv_high == WLIM, "R8 cnv high cycles on timeout", cnv_high, WLIM);
    chk(err, "R8 err after timeout", int'(err), 1);
    chk(falls == 0 && early_tr == 0, "R8 no clocks on timeout", falls + early_tr, 0);
    chk(words_seen == 0, "R8 no words on timeout", words_seen, 0);
    repeat (5) @(negedge clk);
    chk(err, "R8 err holds while idle", int'(err), 1);

    run_cycle(14'h1FFE, 14'h0555, 14'h3C3C, 3, 0);
    chk(!err, "R8 err cleared after next cycle", int'(err), 0);
    report();
  end

endmodule